// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block walks a multi-register load or store. It is handed a 16-bit register list, a base address and the direction, indexing, write-back, load and user-bank controls. It then produces one word access per listed register, presenting the address and register index together and stepping on each accepted memory handshake. It also produces the updated base value and a strobe that tells the register file when to write it. Both the register file and the memory port are outside the block.

At the end of a load the sequencer inserts one idle slot, then raises a one-cycle completion flag. With that flag it marks whether the saved status word must be copied into the current status. While the accesses are running it drives a select that tells the register file to use the user-mode register bank.

An empty list is a special case. It moves only register 15, but the address window and the written-back base behave as if all sixteen registers had been listed.

Top module: `blk_xfer_seq`

## Requirements
- R1: One access is issued per set bit of `reg_list`, in ascending register index order (`xfer_reg` = bit position). The list is captured at `start`.
- R2: An all-zero `reg_list` issues exactly one access, for register 15. Both the start address and the written-back base are computed with a count of 16.
- R3: Each access after the first uses the previous access address plus 4. `xfer_addr[1:0]` is always 0.
- R4: The first address is computed from the effective base B and the count N. With `up`=1 and `pre_index`=1 it is B+4. With `up`=1 and `pre_index`=0 it is B. With `up`=0 it is B−4·N, plus 4 when `pre_index`=0.
- R5: `wb_value` is B+4·N when `up`=1 and B−4·N when `up`=0. With `write_back`=1, `wb_en` pulses for exactly one cycle. On a load the pulse comes in the first cycle after `start`, before any handshake. On a store it comes in the cycle after the first handshake. With `write_back`=0 there is no pulse.
- R6: `xfer_seq` is 0 on the first access of an instruction and 1 on every later access.
- R7: When `base_is_pc`=1 the effective base B is `base_addr`+4; otherwise B is `base_addr`.
- R8: During accesses `user_sel`=1 exactly when `user_bank`=1 and either the operation is a store or register 15 is not in the list.
- R9: `restore_status` is 1 together with `done` exactly when the operation is a load, `user_bank`=1, and register 15 is in the list (an empty list counts as containing register 15).
- R10: A load raises `idle_slot` for one cycle after its last handshake, and `done` follows in the next cycle. A store raises `done` in the cycle right after its last handshake.
- R11: `done` lasts one cycle, after which `busy` is 0. A `start` while `busy`=1 has no effect on the running sequence.
- R12: While `mem_ready`=0 the current access (address, index, sequential flag) is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted when idle) |
| reg_list | input | 16 | Register list, bit i selects register i |
| base_addr | input | ADDR_W | Base register value |
| base_is_pc | input | 1 | Base register is register 15 |
| pre_index | input | 1 | Step before the access (1) or after (0) |
| up | input | 1 | Increment (1) or decrement (0) |
| write_back | input | 1 | Update the base register |
| load | input | 1 | Load (1) or store (0) |
| user_bank | input | 1 | User-bank / status-restore control |
| mem_ready | input | 1 | Memory accepts the current access |
| busy | output | 1 | Sequence in progress |
| xfer_valid | output | 1 | An access is presented |
| xfer_addr | output | ADDR_W | Word address of the access |
| xfer_reg | output | 4 | Register index of the access |
| xfer_seq | output | 1 | Access is sequential |
| user_sel | output | 1 | Use the user-mode register bank |
| idle_slot | output | 1 | Trailing idle cycle of a load |
| wb_en | output | 1 | Write `wb_value` into the base register |
| wb_value | output | ADDR_W | Updated base value |
| done | output | 1 | Sequence complete (one cycle) |
| restore_status | output | 1 | Copy the saved status into the current status |

## Verification
Some properties are checked on every cycle by the bound checker: address alignment, the +4 step and strictly rising register index between consecutive accesses, the sequential flag on follow-on accesses, holding under stall, single-cycle `wb_en` and `done`, and `done` following `idle_slot`. Other properties only show up in the bench's scenarios. These are the exact first address and base result for each indexing mode, the empty-list window, the different write-back timing for loads and stores, the user-bank and status-restore decisions, and a `start` that is ignored mid-sequence.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       reg_list,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              base_is_pc,
  input  logic              pre_index,
  input  logic              up,
  input  logic              write_back,
  input  logic              load,
  input  logic              user_bank,
  input  logic              mem_ready,
  output logic              busy,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [3:0]        xfer_reg,
  output logic              xfer_seq,
  output logic              user_sel,
  output logic              idle_slot,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value,
  output logic              done,
  output logic              restore_status
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_DONE} st_t;

  st_t               state;
  logic [15:0]       mask;
  logic [ADDR_W-1:0] addr_q;
  logic              first_q, load_q, ub_q, r15_q, wbk_q, wb_en_q;
  logic [ADDR_W-1:0] wb_val_q;

  logic [15:0]       list_eff;
  logic [4:0]        cnt;
  logic [ADDR_W-1:0] eff_base, span, first_addr;
  logic [3:0]        low;
  logic              accept, hs;
  logic [15:0]       rest;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < 16; i++) cnt = cnt + {4'd0, reg_list[i]};
    if (reg_list == '0) cnt = 5'd16;
  end

  assign list_eff   = (reg_list == '0) ? 16'h8000 : reg_list;
  assign eff_base   = base_addr + (base_is_pc ? ADDR_W'(4) : ADDR_W'(0));
  assign span       = ADDR_W'({cnt, 2'b00});
  assign first_addr = up ? (pre_index ? eff_base + ADDR_W'(4) : eff_base)
                         : (eff_base - span + (pre_index ? ADDR_W'(0) : ADDR_W'(4)));

  always_comb begin
    low = '0;
    for (int i = 15; i >= 0; i--) if (mask[i]) low = 4'(i);
  end

  assign accept = start && (state == S_IDLE);
  assign hs     = (state == S_XFER) && mem_ready;
  assign rest   = mask & ~(16'd1 << low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mask     <= '0;
      addr_q   <= '0;
      first_q  <= 1'b0;
      load_q   <= 1'b0;
      ub_q     <= 1'b0;
      r15_q    <= 1'b0;
      wbk_q    <= 1'b0;
      wb_val_q <= '0;
      wb_en_q  <= 1'b0;
    end else begin
      wb_en_q <= (accept && load && write_back) || (hs && first_q && !load_q && wbk_q);
      case (state)
        S_IDLE: if (accept) begin
          state    <= S_XFER;
          mask     <= list_eff;
          addr_q   <= first_addr;
          first_q  <= 1'b1;
          load_q   <= load;
          ub_q     <= user_bank;
          r15_q    <= list_eff[15];
          wbk_q    <= write_back;
          wb_val_q <= up ? eff_base + span : eff_base - span;
        end
        S_XFER: if (mem_ready) begin
          mask    <= rest;
          addr_q  <= addr_q + ADDR_W'(4);
          first_q <= 1'b0;
          if (rest == '0) state <= load_q ? S_GAP : S_DONE;
        end
        S_GAP:   state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy           = (state != S_IDLE);
  assign xfer_valid     = (state == S_XFER);
  assign xfer_addr      = {addr_q[ADDR_W-1:2], 2'b00};
  assign xfer_reg       = low;
  assign xfer_seq       = !first_q;
  assign user_sel       = xfer_valid && ub_q && (!load_q || !r15_q);
  assign idle_slot      = (state == S_GAP);
  assign wb_en          = wb_en_q;
  assign wb_value       = wb_val_q;
  assign done           = (state == S_DONE);
  assign restore_status = done && load_q && ub_q && r15_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_ready,
  input logic              busy,
  input logic              xfer_valid,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [3:0]        xfer_reg,
  input logic              xfer_seq,
  input logic              idle_slot,
  input logic              wb_en,
  input logic              done
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_addr[1:0] == 2'b00); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && mem_ready) ##1 xfer_valid |-> xfer_addr == $past(xfer_addr) + ADDR_W'(4)); // R3
  AST_REG_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && mem_ready) ##1 xfer_valid |-> xfer_reg > $past(xfer_reg)); // R1
  AST_SEQ_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && mem_ready) ##1 xfer_valid |-> xfer_seq); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !mem_ready) |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_reg) && $stable(xfer_seq)); // R12
  AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R11
  AST_GAP_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_slot |=> done); // R10
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .busy(busy),
  .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
  .xfer_seq(xfer_seq), .idle_slot(idle_slot), .wb_en(wb_en), .done(done)
);

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reg_list = '0;
  logic [31:0] base_addr = '0;
  logic        base_is_pc = 1'b0, pre_index = 1'b0, up = 1'b0, write_back = 1'b0;
  logic        load = 1'b0, user_bank = 1'b0, mem_ready = 1'b1;
  logic        busy, xfer_valid, xfer_seq, user_sel, idle_slot, wb_en, done, restore_status;
  logic [31:0] xfer_addr, wb_value;
  logic [3:0]  xfer_reg;

  blk_xfer_seq uut (.*);

  always #4 clk = ~clk;

  int vectors = 0, fails = 0;
  logic [31:0] q_addr[$];
  logic [3:0]  q_reg[$];
  logic        q_seq[$];
  logic [31:0] exp_wb;
  bit exp_load, exp_user, exp_restore, stall_en, last_idle, done_seen;
  int hs_cnt, wb_cnt;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = stall_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (wb_en) begin
      wb_cnt++;
      chk(wb_value == exp_wb, "R5 wb_value", wb_value, exp_wb);
      chk(hs_cnt == (exp_load ? 0 : 1), "R5 wb timing", hs_cnt, exp_load ? 0 : 1);
    end
    if (xfer_valid && mem_ready) begin
      if (q_addr.size() == 0) chk(0, "R1 extra access", {28'd0, xfer_reg}, 0);
      else begin
        logic [31:0] ea; logic [3:0] er; logic es;
        ea = q_addr.pop_front(); er = q_reg.pop_front(); es = q_seq.pop_front();
        chk(xfer_addr == ea, "R3/R4 address", xfer_addr, ea);
        chk(xfer_reg == er, "R1/R2 register", {28'd0, xfer_reg}, {28'd0, er});
        chk(xfer_seq == es, "R6 seq", {31'd0, xfer_seq}, {31'd0, es});
        chk(user_sel == exp_user, "R8 user_sel", {31'd0, user_sel}, {31'd0, exp_user});
      end
      hs_cnt++;
    end
    if (done) begin
      chk(restore_status == exp_restore, "R9 restore", {31'd0, restore_status}, {31'd0, exp_restore});
      chk(q_addr.size() == 0, "R1 missing accesses", q_addr.size(), 0);
      chk(last_idle == exp_load, "R10 idle slot", {31'd0, last_idle}, {31'd0, exp_load});
      done_seen = 1;
    end
    last_idle = idle_slot;
  end

  task automatic run_op(input logic [15:0] lst, input logic [31:0] b, input bit pc, pr, u, w, l, ub,
                        input bit stall, input bit poke);
    logic [31:0] eff, a, first;
    logic [15:0] m;
    int cnt;
    bit s;
    eff = b + (pc ? 32'd4 : 32'd0);
    m = lst; cnt = 0;
    for (int i = 0; i < 16; i++) cnt += lst[i];
    if (lst == 0) begin m = 16'h8000; cnt = 16; end
    first = u ? (pr ? eff + 4 : eff) : eff - 32'(4 * cnt) + (pr ? 32'd0 : 32'd4);
    a = first; s = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin
      q_addr.push_back({a[31:2], 2'b00}); q_reg.push_back(4'(i)); q_seq.push_back(s);
      a += 4; s = 1;
    end
    exp_wb = u ? eff + 32'(4 * cnt) : eff - 32'(4 * cnt);
    exp_load = l; exp_user = ub && (!l || !m[15]); exp_restore = l && ub && m[15];
    hs_cnt = 0; wb_cnt = 0; done_seen = 0; stall_en = stall;
    @(posedge clk); #1;
    reg_list = lst; base_addr = b; base_is_pc = pc; pre_index = pr; up = u;
    write_back = w; load = l; user_bank = ub; start = 1;
    @(posedge clk); #1; start = 0;
    if (poke) begin
      @(posedge clk); #1;
      reg_list = 16'h00F0; base_addr = 32'h5555_0000; up = ~u; load = ~l; start = 1; // R11 ignored start
      @(posedge clk); #1; start = 0;
    end
    while (!done_seen) @(negedge clk);
    @(posedge clk); #1;
    chk(wb_cnt == (w ? 1 : 0), "R5 wb count", wb_cnt, w ? 1 : 0);
    chk(!busy && !done, "R11 end state", {30'd0, busy, done}, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !xfer_valid && !done && !wb_en, "reset state", {28'd0, busy, xfer_valid, done, wb_en}, 0);
    rst_n = 1;
    // increment after, store, write-back (R4 R5 R1)
    run_op(16'b0000_0000_1010_0110, 32'h0000_1000, 0, 0, 1, 1, 0, 0, 0, 0);
    // increment before, load, write-back, stalls (R4 R5 R10 R12)
    run_op(16'b1000_0001_0000_0001, 32'h0000_2000, 0, 1, 1, 1, 1, 0, 1, 0);
    // decrement before, store (R4)
    run_op(16'b0000_0011_1100_0000, 32'h0000_3000, 0, 1, 0, 1, 0, 0, 1, 0);
    // decrement after, load, no write-back (R4 R5)
    run_op(16'b0111_0000_0000_1000, 32'h0000_4000, 0, 0, 0, 0, 1, 0, 0, 0);
    // empty list, increment after, store (R2)
    run_op(16'h0000, 32'h0000_5000, 0, 0, 1, 1, 0, 0, 0, 0);
    // empty list, decrement before, load with user bank: restore (R2 R9)
    run_op(16'h0000, 32'h0000_6000, 0, 1, 0, 1, 1, 1, 1, 0);
    // base is PC, unaligned low bits (R7 R3)
    run_op(16'b0000_0000_0001_1001, 32'h0000_7002, 1, 1, 1, 1, 1, 0, 0, 0);
    // user bank store (R8)
    run_op(16'b0100_0000_0000_0011, 32'h0000_8000, 0, 0, 1, 1, 0, 1, 1, 0);
    // user bank load without R15 (R8 R9)
    run_op(16'b0000_1111_0000_0000, 32'h0000_9000, 0, 1, 1, 0, 1, 1, 0, 0);
    // user bank load with R15: restore, no user select (R8 R9)
    run_op(16'b1000_0000_0000_0100, 32'h0000_A000, 0, 0, 1, 1, 1, 1, 1, 0);
    // full list with ignored start while busy (R11 R1)
    run_op(16'hFFFF, 32'h0000_B000, 0, 0, 1, 1, 0, 0, 1, 1);
    // single register load, decrement after (R10 R4)
    run_op(16'b0000_0000_0010_0000, 32'h0000_C000, 0, 0, 0, 1, 1, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule